// File: doc/BRIEF.md
# PRBS23 Built-In Self-Test Pattern Source and Checker

This block gives one transceiver channel a self-test path. Its transmit half produces a pseudo-noise bit stream from a 23-bit shift register with feedback polynomial 1 + x^5 + x^23. The stream is delivered as 10-bit code groups on a valid/ready interface. Its receive half watches incoming 10-bit groups and fills its own 23-bit reference register from the first 23 received bits. From then on it predicts every later bit and compares it with the received bit. A group with at least one wrong bit counts as one error in an 8-bit counter that stops at 255 and never wraps.

System logic enables the block with a single level input. While the input is low, both shift registers stay at their starting state and the error count keeps its last value. On the first cycle the input is high, the count clears. The count then follows the received stream for as long as the input stays high. Bits travel least significant first: bit 0 of a group is the earliest bit in the sequence.

Back-pressure rules. On the transmit side a group is handed over only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. The receive side has no ready signal. The checker takes every group marked by `rx_valid` in the cycle it appears, so the sender upstream is never stalled.

Top module: `prbs23_bist`

## Requirements
- R1: While `rst_n` is low and after its release, `err_count` is 0 and `tx_valid` is 0 until `bist_en` is raised.
- R2: The generator register starts at all ones (23'h7FFFFF) after reset and whenever `bist_en` is low. Each new bit is register bit 22 XOR register bit 4, and that bit is shifted in at bit 0. The ten bits of a group are produced into `tx_data[0]` first, up to `tx_data[9]`.
- R3: `tx_valid` equals `bist_en`. The generator moves to its next group only when `tx_valid` and `tx_ready` are both high, and `tx_data` holds while `tx_ready` is low.
- R4: After BIST entry the checker loads the first 23 bits it receives, bit 0 of each group first, straight into its reference register without comparing them. Every later bit is compared with the reference's prediction, and the reference then advances on its own prediction.
- R5: A received group with one or more mismatching compared bits adds exactly one to `err_count`, whatever the number of wrong bits.
- R6: `err_count` stops at 8'hFF and stays there on further errors.
- R7: `err_count` goes to 0 on the first cycle `bist_en` is high after being low. While `bist_en` is low, the count holds and received groups have no effect.
- R8: A cycle with `rx_valid` low does not change the count or the checker state.
- R9: After 8 consecutive erroneous groups, the checker refills its reference from the next 23 received bits. Counting continues during the refill.
- R10: `err_count` shows the result of a group on the clock edge that accepts it, so the new value can be read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Self-test enable level |
| tx_ready | input | 1 | Transmit path accepts the current group |
| tx_valid | output | 1 | Generated group is available |
| tx_data | output | 10 | Generated code group, bit 0 earliest |
| rx_valid | input | 1 | Received group present this cycle |
| rx_data | input | 10 | Received code group, bit 0 earliest |
| err_count | output | 8 | Saturating count of mismatching groups |

## Verification
The assertions check on every cycle that the transmit group holds under back-pressure, that the generator register is never zero, and that the count grows by at most one per cycle. They also check that the count stays at its maximum, clears on entry, and holds while the block is idle, and that the checker's fill and error-run counters stay in range. Only the bench scenarios can show the end-to-end behaviour. That includes the exact bit sequence against an independent model of the polynomial and the 23-bit load window spanning three groups. It also includes the refill after 8 bad groups, which recovers from a dropped group, and saturation after several hundred complemented groups.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;
  localparam int PN_W   = 23;
  localparam int PN_TAP = 5;

  // next bit of the sequence from the last PN_W bits (bit 0 newest)
  function automatic logic pn_next_bit(input logic [PN_W-1:0] s);
    return s[PN_W-1] ^ s[PN_TAP-1];
  endfunction
endpackage

// File: rtl/prbs_pn_gen.sv
module prbs_pn_gen
  import prbs_bist_pkg::*;
#(
  parameter int              GW   = 10,
  parameter logic [PN_W-1:0] SEED = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          adv,
  output logic [GW-1:0] data
);
  logic [PN_W-1:0] state_q;
  logic [PN_W-1:0] state_d;

  always_comb begin
    logic [PN_W-1:0] s;
    logic            b;
    s = state_q;
    data = '0;
    for (int i = 0; i < GW; i++) begin
      b = pn_next_bit(s);
      data[i] = b;
      s = {s[PN_W-2:0], b};
    end
    state_d = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEED;
    else if (!run) state_q <= SEED;
    else if (adv)  state_q <= state_d;
  end

  assert_hold_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !adv) |=> (!run || $stable(data)));

  assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/prbs_pn_chk.sv
module prbs_pn_chk
  import prbs_bist_pkg::*;
#(
  parameter int GW         = 10,
  parameter int RELOCK_RUN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          grp_valid,
  input  logic [GW-1:0] grp_data,
  output logic          grp_err
);
  localparam int FW = $clog2(PN_W + 1);
  localparam int RW = $clog2(RELOCK_RUN + 1);

  logic [PN_W-1:0] ref_q, ref_d;
  logic [FW-1:0]   fill_q, fill_d;
  logic [RW-1:0]   errrun_q;
  logic            miss;
  logic            take;
  logic            relock;

  always_comb begin
    logic [PN_W-1:0] r;
    logic            p;
    int              f;
    r    = ref_q;
    f    = int'(fill_q);
    miss = 1'b0;
    for (int i = 0; i < GW; i++) begin
      p = pn_next_bit(r);
      if (f < PN_W) begin
        r = {r[PN_W-2:0], grp_data[i]};
        f = f + 1;
      end else begin
        miss = miss | (p ^ grp_data[i]);
        r = {r[PN_W-2:0], p};
      end
    end
    ref_d  = r;
    fill_d = FW'(f);
  end

  assign take    = run && grp_valid;
  assign grp_err = take && miss;
  assign relock  = grp_err && (int'(errrun_q) + 1 >= RELOCK_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0; fill_q <= '0; errrun_q <= '0;
    end else if (!run) begin
      ref_q <= '0; fill_q <= '0; errrun_q <= '0;
    end else if (take) begin
      ref_q <= ref_d;
      if (relock) begin
        fill_q   <= '0;
        errrun_q <= '0;
      end else begin
        fill_q   <= fill_d;
        errrun_q <= miss ? errrun_q + 1'b1 : '0;
      end
    end
  end

  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(PN_W));

  assert_run_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(errrun_q) < RELOCK_RUN);
endmodule

// File: rtl/prbs_err_counter.sv
module prbs_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (clr)                   count <= '0;
    else if (inc && count != MAXV)  count <= count + 1'b1;
  end

  assert_hold_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV && !clr) |=> count == MAXV);

  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/prbs23_bist.sv
module prbs23_bist #(
  parameter int GW         = 10,
  parameter int CNT_W      = 8,
  parameter int RELOCK_RUN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bist_en,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [GW-1:0]    tx_data,
  input  logic             rx_valid,
  input  logic [GW-1:0]    rx_data,
  output logic [CNT_W-1:0] err_count
);
  logic bist_q;
  logic entry;
  logic grp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bist_q <= 1'b0;
    else        bist_q <= bist_en;
  end

  assign entry    = bist_en && !bist_q;
  assign tx_valid = bist_en;

  prbs_pn_gen #(.GW(GW)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(bist_en),
    .adv(tx_valid && tx_ready), .data(tx_data)
  );

  prbs_pn_chk #(.GW(GW), .RELOCK_RUN(RELOCK_RUN)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(bist_en),
    .grp_valid(rx_valid), .grp_data(rx_data), .grp_err(grp_err)
  );

  prbs_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(entry), .inc(grp_err), .count(err_count)
  );

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> $stable(err_count));

  assert_entry_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_en) |=> err_count == '0);
endmodule

// File: tb/sim_prbs23_bist.sv
module sim_prbs23_bist;
  logic       clk = 1'b0;
  logic       rst_n, bist_en, tx_ready, rx_valid;
  logic [9:0] rx_data;
  logic       tx_valid;
  logic [9:0] tx_data;
  logic [7:0] err_count;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic [22:0] mdl;

  always #5 clk = ~clk;

  prbs23_bist u0 (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .err_count(err_count)
  );

  // {error mask, expected count after the group}; groups 0..2 are clean (fill)
  localparam logic [17:0] VEC [8] = '{
    {10'h000, 8'd0}, {10'h000, 8'd0}, {10'h000, 8'd0}, {10'h001, 8'd1},
    {10'h3FF, 8'd2}, {10'h000, 8'd2}, {10'h200, 8'd3}, {10'h000, 8'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected next group from the model (R2), advancing the model
  task automatic mdl_group(output logic [9:0] g);
    logic b;
    for (int i = 0; i < 10; i++) begin
      b = mdl[22] ^ mdl[4];
      g[i] = b;
      mdl = {mdl[21:0], b};
    end
  endtask

  task automatic cyc(input logic rdy, input logic rv, input logic [9:0] rd);
    tx_ready = rdy; rx_valid = rv; rx_data = rd;
    @(posedge clk);
    @(negedge clk);
  endtask

  // transmit one group and loop it back with a bit-flip mask
  task automatic lb(input logic [9:0] mask);
    logic [9:0] g;
    mdl_group(g);
    check("R2 tx group", int'(tx_data), int'(g));
    cyc(1'b1, 1'b1, tx_data ^ mask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    rst_n = 1'b0; bist_en = 1'b0; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", int'(err_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after reset", int'(err_count), 0);
    check("R1 tx_valid after reset", int'(tx_valid), 0);

    // idle: received groups ignored (R7)
    repeat (3) cyc(1'b1, 1'b1, 10'h3FF);
    check("R7 idle rx ignored", int'(err_count), 0);
    check("R3 tx_valid idle", int'(tx_valid), 0);

    // enter BIST
    bist_en = 1'b1;
    mdl = 23'h7FFFFF;
    #1;
    check("R3 tx_valid follows enable", int'(tx_valid), 1);
    begin
      logic [9:0] first;
      first = tx_data;
      cyc(1'b0, 1'b0, 10'h000);
      check("R3 data held without ready", int'(tx_data), int'(first));
    end

    // table: fill, single-bit, all-bit and high-bit errors (R4 R5 R10)
    for (int k = 0; k < 8; k++) begin
      lb(VEC[k][17:8]);
      check("R5 R10 table count", int'(err_count), int'(VEC[k][7:0]));
    end

    // rx_valid low: no effect, even with garbage and tx stalled (R8)
    cyc(1'b0, 1'b0, 10'h155);
    cyc(1'b0, 1'b0, 10'h2AA);
    check("R8 invalid rx ignored", int'(err_count), 3);
    lb(10'h000); lb(10'h000);
    check("R8 alignment kept", int'(err_count), 3);

    // 8 fully wrong groups, then a dropped group; refill must recover (R9)
    for (int k = 0; k < 7; k++) lb(10'h3FF);
    check("R9 seven errors", int'(err_count), 10);
    lb(10'h3FF);
    check("R9 eighth error", int'(err_count), 11);
    begin
      logic [9:0] g;
      mdl_group(g);
      cyc(1'b1, 1'b0, 10'h000);
    end
    for (int k = 0; k < 10; k++) lb(10'h000);
    check("R9 relocked after slip", int'(err_count), 11);

    // exit holds, re-entry clears (R7)
    bist_en = 1'b0;
    cyc(1'b0, 1'b0, 10'h000);
    check("R3 tx_valid after exit", int'(tx_valid), 0);
    repeat (2) cyc(1'b1, 1'b1, 10'h3FF);
    check("R7 count held while idle", int'(err_count), 11);
    bist_en = 1'b1;
    mdl = 23'h7FFFFF;
    cyc(1'b0, 1'b0, 10'h000);
    check("R7 cleared on entry", int'(err_count), 0);

    // saturation with complemented stream (R6)
    prev = err_count;
    for (int k = 0; k < 600; k++) begin
      lb(10'h3FF);
      if (err_count < prev) check("R6 no wrap", int'(err_count), int'(prev));
      prev = err_count;
    end
    check("R6 saturated", int'(err_count), 255);
    repeat (5) lb(10'h3FF);
    check("R6 stays at max", int'(err_count), 255);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule